// File: doc/BRIEF.md
# Fuse-configured sum-of-products logic array

This block is the logic plane of a small programmable logic device. A set of dedicated inputs, together with the sensed levels of the block's own output pads, forms the array inputs. Each array input reaches every product term twice: once as itself and once inverted. A bank of AND product terms picks its literals through a flat vector of configuration links. A fixed OR stage then combines the terms that belong to each output. No OR term is shared between outputs.

Each output owns a group of consecutive terms. The first term of the group is not summed. It drives the enable of the output's tri-state pad driver. When that driver is on, the pad is driven low for a true sum (active low). When it is off, the pad floats. The feedback bus then carries whatever level drives the pad from outside.

The configuration vector is captured into the block on every clock edge while reset is high. After reset it is held. Changes on the configuration input are then ignored. With the default parameters the block has 10 dedicated inputs, 8 outputs and 8 terms per output group. The expected configuration length is checked at elaboration.

Top module: `sop_array`

## Requirements
- R1: Array input k is `in_i[k]` for k < N_IN and `fb_i[k-N_IN]` above that. Every array input is offered to every product term as a true literal and as a complemented literal.
- R2: Configuration bit `t*2*(N_IN+N_OUT) + 2*k` is the true-literal link of array input k in term t. The bit one above it is the complemented-literal link. A bit value of 0 means the link is intact and the literal takes part in the AND. A value of 1 means the link is blown and the literal is left out.
- R3: A term with every link intact contains a literal and its complement, so it always evaluates to 0.
- R4: A term with every link blown always evaluates to 1.
- R5: Output o owns terms o*TPO to o*TPO+TPO-1. `sum_o[o]` is the OR of local terms 1 to TPO-1 of that group only. Terms of other groups have no effect on it.
- R6: Local term 0 of each group drives `oe_o[o]` and does not contribute to `sum_o[o]`.
- R7: When `oe_o[o]` is 1, `pin_o[o]` equals the inverse of `sum_o[o]` (active low). When it is 0, `pin_o[o]` is high impedance.
- R8: `fb_i[j]` is the sensed pad level of output j. Equations that use it follow it whether or not that output's driver is enabled.
- R9: While `rst` is 1, each rising clock edge loads `cfg_i`. While `rst` is 0, changes on `cfg_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration capture |
| rst | input | 1 | Active-high reset; configuration is loaded while high |
| cfg_i | input | CFG_W | Link vector, 1 = blown, 0 = intact |
| in_i | input | N_IN | Dedicated inputs |
| fb_i | input | N_OUT | Sensed pad levels fed back into the array |
| sum_o | output | N_OUT | OR of each output's sum terms |
| oe_o | output | N_OUT | Driver enable from each group's first term |
| pin_o | output | N_OUT | Active-low pad value, high impedance when disabled |

## Verification
The bench builds the block with 4 dedicated inputs, 2 outputs and 9 terms per group. With this size every input and feedback combination can be swept exhaustively. Nine terms per group leave eight sum terms, enough for a 4-input odd-parity function written as its eight minterms. It is compared against parity counted in the bench. The second output mixes a feedback literal with an input literal, uses an input-controlled enable term and fills its spare terms with all-intact terms. This exposes cross-group leakage, enable and sum mix-ups, and wrong literal polarity. Reloading with a fully blown term, and changing the configuration input after reset, cover the constant-one term and the load window.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Bit position of one link in the flat configuration vector.
  // comp = 0 selects the true literal, comp = 1 the inverted one.
  function automatic int link_pos(input int term, input int arr_in,
                                  input int comp, input int n_arr);
    return term * 2 * n_arr + 2 * arr_in + comp;
  endfunction

  // Number of configuration bits the array needs.
  function automatic int cfg_bits(input int n_in, input int n_out,
                                  input int tpo);
    return n_out * tpo * 2 * (n_in + n_out);
  endfunction

endpackage

// File: rtl/sop_term_bank.sv
module sop_term_bank #(
  parameter int N_ARR  = 18,
  parameter int N_TERM = 64,
  localparam int N_LIT = 2 * N_ARR
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_TERM*N_LIT-1:0] fuse_i,
  input  logic [N_ARR-1:0]        arr_i,
  output logic [N_TERM-1:0]       term_o
);
  import sop_pkg::*;

  // Literal rail: even slots carry the input, odd slots its inverse.
  logic [N_LIT-1:0] lit_rail;

  always_comb begin
    for (int k = 0; k < N_ARR; k++) begin
      lit_rail[link_pos(0, k, 0, N_ARR)] = arr_i[k];
      lit_rail[link_pos(0, k, 1, N_ARR)] = ~arr_i[k];
    end
  end

  genvar t;
  generate
    for (t = 0; t < N_TERM; t++) begin : g_term
      logic [N_LIT-1:0] links;
      logic             all_intact;
      logic             all_blown;

      assign links      = fuse_i[t*N_LIT +: N_LIT];
      // A blown link forces its AND input to 1, removing the literal.
      assign term_o[t]  = &(lit_rail | links);
      assign all_intact = ~|links;
      assign all_blown  = &links;

      assert_intact_zero_R3: assert property (@(posedge clk) disable iff (rst)
        all_intact |-> !term_o[t]);
      assert_blown_one_R4: assert property (@(posedge clk) disable iff (rst)
        all_blown |-> term_o[t]);
    end
  endgenerate

endmodule

// File: rtl/sop_or_stage.sv
module sop_or_stage #(
  parameter int N_OUT = 8,
  parameter int TPO   = 8
) (
  input  logic [N_OUT*TPO-1:0] term_i,
  output logic [N_OUT-1:0]     sum_o,
  output logic [N_OUT-1:0]     oe_o
);

  genvar o;
  generate
    for (o = 0; o < N_OUT; o++) begin : g_out
      logic [TPO-1:0] grp;
      assign grp      = term_i[o*TPO +: TPO];
      assign oe_o[o]  = grp[0];
      assign sum_o[o] = |grp[TPO-1:1];
    end
  endgenerate

endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN  = 10,
  parameter int N_OUT = 8,
  parameter int TPO   = 8,
  parameter int CFG_W = N_OUT * TPO * 2 * (N_IN + N_OUT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_OUT-1:0] fb_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o,
  output logic [N_OUT-1:0] pin_o
);
  import sop_pkg::*;

  localparam int N_ARR    = N_IN + N_OUT;
  localparam int N_TERM   = N_OUT * TPO;
  localparam int CFG_NEED = cfg_bits(N_IN, N_OUT, TPO);

  generate
    if (CFG_W != CFG_NEED) begin : g_bad_cfg_w
      $error("sop_array: CFG_W does not match the array size");
    end
    if (TPO < 2) begin : g_bad_tpo
      $error("sop_array: each group needs an enable term and a sum term");
    end
  endgenerate

  // Configuration held after reset.
  logic [CFG_W-1:0]  cfg_q;
  logic [N_ARR-1:0]  arr_w;
  logic [N_TERM-1:0] term_w;
  logic [N_OUT-1:0]  sum_w;
  logic [N_OUT-1:0]  oe_w;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_i;
  end

  // Array inputs: dedicated pins first, then sensed pad levels.
  assign arr_w = {fb_i, in_i};

  sop_term_bank #(
    .N_ARR  (N_ARR),
    .N_TERM (N_TERM)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .fuse_i (cfg_q),
    .arr_i  (arr_w),
    .term_o (term_w)
  );

  sop_or_stage #(
    .N_OUT  (N_OUT),
    .TPO    (TPO)
  ) u_or (
    .term_i (term_w),
    .sum_o  (sum_w),
    .oe_o   (oe_w)
  );

  assign sum_o = sum_w;
  assign oe_o  = oe_w;

  genvar o;
  generate
    for (o = 0; o < N_OUT; o++) begin : g_pad
      assign pin_o[o] = oe_w[o] ? ~sum_w[o] : 1'bz;

      assert_sum_idle_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones(term_w[o*TPO+1 +: TPO-1]) == 0) |-> !sum_w[o]);
      assert_oe_follows_R6: assert property (@(posedge clk) disable iff (rst)
        term_w[o*TPO] |-> oe_w[o]);
      assert_pin_low_true_R7: assert property (@(posedge clk) disable iff (rst)
        oe_w[o] |-> (pin_o[o] == !sum_w[o]));
    end
  endgenerate

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg_q));

endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb_top;
  localparam int N_IN  = 4;
  localparam int N_OUT = 2;
  localparam int TPO   = 9;
  localparam int NA    = N_IN + N_OUT;
  localparam int NL    = 2 * NA;
  localparam int CW    = N_OUT * TPO * NL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg_i = '0;
  logic [N_IN-1:0]  in_i = '0;
  logic [N_OUT-1:0] fb_i = '0;
  logic [N_OUT-1:0] sum_o, oe_o, pin_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sop_array #(.N_IN(N_IN), .N_OUT(N_OUT), .TPO(TPO), .CFG_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .in_i(in_i), .fb_i(fb_i),
    .sum_o(sum_o), .oe_o(oe_o), .pin_o(pin_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s in=%0h fb=%0h actual=%0h expected=%0h", req, in_i, fb_i, act, exp);
    end
  endtask

  // Link index restated from R2: term-major, true link then complement link.
  function automatic int lk(input int t, input int k, input int c);
    return (t * NL) + (k * 2) + c;
  endfunction

  // Build configuration: cfg_a (parity + feedback equations), cfg_b adds a
  // fully blown sum term to output 1.
  function automatic logic [CW-1:0] build_cfg(input bit blown_spare);
    logic [CW-1:0] v;
    int slot;
    v = '1;  // everything blown; output 0 enable term is therefore 1 (R4)
    slot = 1;
    for (int m = 0; m < 16; m++) begin
      int ones;
      ones = 0;
      for (int b = 0; b < 4; b++) ones += (m >> b) & 1;
      if (ones % 2 == 1) begin
        for (int k = 0; k < N_IN; k++) begin
          if (((m >> k) & 1) == 1) v[lk(slot, k, 0)] = 1'b0;
          else                     v[lk(slot, k, 1)] = 1'b0;
        end
        slot++;
      end
    end
    // Output 1: enable = in[3] true literal.
    v[lk(TPO, 3, 0)] = 1'b0;
    // Output 1 term 1: fb[0] AND in[0].
    v[lk(TPO + 1, 0, 0)] = 1'b0;
    v[lk(TPO + 1, N_IN + 0, 0)] = 1'b0;
    // Remaining output 1 terms fully intact (always 0, R3).
    for (int t = TPO + 2; t < 2 * TPO; t++)
      for (int b = 0; b < NL; b++) v[t * NL + b] = 1'b0;
    if (blown_spare)
      for (int b = 0; b < NL; b++) v[(TPO + 2) * NL + b] = 1'b1;
    return v;
  endfunction

  function automatic logic odd_par(input logic [3:0] x);
    int c;
    c = 0;
    for (int b = 0; b < 4; b++) if (x[b]) c++;
    return (c % 2) == 1;
  endfunction

  task automatic sweep(input bit spare_one);
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 16; i++) begin
        logic ep, e1, eo1;
        @(negedge clk);
        in_i = i[3:0];
        fb_i = f[1:0];
        #1;
        ep  = odd_par(i[3:0]);
        e1  = spare_one ? 1'b1 : (f[0] & i[0]);
        eo1 = i[3];
        chk("R5 parity sum", sum_o[0], ep);
        chk("R4 enable all blown", oe_o[0], 1'b1);
        chk("R7 active-low pin0", pin_o[0], !ep);
        chk("R6 enable from term0", oe_o[1], eo1);
        chk(spare_one ? "R4 blown sum term" : "R8 R1 feedback literal", sum_o[1], e1);
        if (eo1) chk("R7 active-low pin1", pin_o[1], !e1);
      end
    end
  endtask

  initial begin
    logic [CW-1:0] cfg_a;
    logic [CW-1:0] cfg_b;
    cfg_a = build_cfg(1'b0);
    cfg_b = build_cfg(1'b1);

    // Reset with every link intact: all terms 0 (R3).
    rst = 1'b1;
    cfg_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 reset all intact sum", sum_o, '0);
    chk("R3 reset all intact oe", oe_o, '0);

    // Load parity configuration (R9 load, R2 layout).
    cfg_i = cfg_a;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    sweep(1'b0);

    // Configuration changes after reset are ignored (R9).
    @(negedge clk);
    cfg_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_i = 4'b1001;
    fb_i = 2'b01;
    #1;
    chk("R9 cfg ignored sum0", sum_o[0], 1'b0);
    chk("R9 cfg ignored sum1", sum_o[1], 1'b1);
    chk("R9 cfg ignored oe", oe_o, 2'b11);
    in_i = 4'b0111;
    #1;
    chk("R9 cfg ignored parity", sum_o[0], 1'b1);

    // Reload with a fully blown sum term in output 1 (R4, R5 isolation).
    @(negedge clk);
    rst = 1'b1;
    cfg_i = cfg_b;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    sweep(1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule